// File: doc/BRIEF.md
# Page-Buffered Write and Read Controller

This block sits behind a serial command decoder for a small byte-addressed nonvolatile array. After the decoder has recognised a write command for this device it hands over the received bytes. The first byte is a word address and the rest are data bytes. The data bytes are collected in a 16-entry page buffer. Nothing reaches the array until a STOP event arrives. The block then steps through the buffer and writes only the locations that received data. After that it holds a busy interval, modelled as a cycle count, standing in for the internally timed programming time. While busy, the block acknowledges nothing and ignores every command.

Reads are served from an internal address pointer. A current-address read starts wherever the last access left the pointer. A random read is a write command that carries only an address, followed by a read command without a STOP in between. A sequential read moves on by one byte for each acknowledge from the controller. It ends after a not-acknowledge, and the pointer wraps from the top address to zero.

A level input enables a one-time protection fuse. When the fuse is set, writes aimed at the protected region are still acknowledged on the bus but leave the array untouched. With an 8-bit address the protected region is the lower half of the array; with a narrower address it is the whole array.

Top module: `pgw_ctrl`

States: ST_IDLE (waiting for a command), ST_WADDR (expecting the word address), ST_WDATA (collecting data bytes), ST_RDATA (presenting read data), ST_RDONE (read ended by not-acknowledge, waiting for STOP), ST_COMMIT (stepping through the buffer, one entry per cycle), ST_BUSY (timed write interval). Transitions:
- ST_IDLE goes to ST_WADDR on a write command and to ST_RDATA on a read command.
- ST_WADDR goes to ST_WDATA on a received byte, to ST_RDATA on a read command (repeated start), and to ST_IDLE on STOP.
- ST_WDATA goes to ST_RDATA on a read command. On STOP it goes to ST_COMMIT if any data was buffered, otherwise to ST_IDLE.
- ST_RDATA goes to ST_RDONE on a not-acknowledge and to ST_IDLE on STOP.
- ST_RDONE goes to ST_IDLE on STOP, to ST_WADDR on a write command and to ST_RDATA on a read command.
- ST_COMMIT goes to ST_BUSY after the last buffer entry.
- ST_BUSY goes to ST_IDLE when the timer expires.

## Requirements
- R1: After reset, busy, ack_out and mem_we are 0, and the address pointer is 0, so the first current-address read returns the byte at address 0.
- R2: After a write command, the first received byte sets the word address. Each following data byte goes to the next location, and the data reaches the array after STOP.
- R3: Data bytes past the end of a 16-byte page (page starts at multiples of 16, column = address bits 3:0) wrap to column 0 of the same page. Bytes past the 16th overwrite the earlier ones, and the page bits never change.
- R4: Only page locations that received data in the current write are written to the array. All other locations keep their contents.
- R5: No array write happens before STOP. busy rises in the cycle after a STOP that ends a write with data, and stays high for exactly 16 + WC_CYCLES cycles.
- R6: While busy is high, ack_out is 0, rd_data is 0, and commands and bytes have no effect on the array or on the pointer.
- R7: The pointer advances after every access. After a read it holds the last read address plus one. After a write with data it holds the location after the last written byte, within that page.
- R8: A read presents the byte at the pointer on rd_data. host_ack with ack_val=1 moves on to the next byte, and ack_val=0 ends the read. The pointer wraps from the top address (FFh for ADDR_W=8) to 00h.
- R9: A write command that carries only an address sets the pointer and writes nothing. Whether it ends with STOP or with a repeated read command, busy stays 0.
- R10: With prot_fuse=1, addresses up to PROT_TOP are never written: 7Fh for ADDR_W=8 (lower half), or the whole array for ADDR_W<8. Bytes aimed there are still acknowledged.
- R11: When not busy, ack_out is 1 in any cycle with cmd_wr or cmd_rd, and in any cycle with rx_valid during the address or data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Write command strobe for this device |
| cmd_rd | input | 1 | Read command strobe (also a repeated start) |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received address or data byte |
| host_ack | input | 1 | Controller response strobe after a read byte |
| ack_val | input | 1 | 1 = acknowledge, 0 = not-acknowledge |
| stop | input | 1 | STOP event strobe |
| prot_fuse | input | 1 | Write protection fuse state |
| mem_rdata | input | 8 | Array read data at mem_addr |
| ack_out | output | 1 | Device acknowledges this cycle |
| busy | output | 1 | Commit or timed write interval in progress |
| rd_data | output | 8 | Read byte presented to the bus shifter |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench builds the block with ADDR_W=8, PAGE_BYTES=16 and WC_CYCLES=20. The 8-bit address lets a sequential read cross FFh into 00h, and it places the protection boundary at 7Fh, so protected and open pages can both be written in one run. A short timed interval keeps each write near 40 cycles, which leaves room for many random page writes, including some longer than 16 bytes, and for commands injected in the middle of a busy window.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WADDR,
        ST_WDATA,
        ST_RDATA,
        ST_RDONE,
        ST_COMMIT,
        ST_BUSY
    } pgw_state_e;
endpackage

// File: rtl/pgw_pagebuf.sv
module pgw_pagebuf #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             any_valid
);
    logic [7:0]       data_q [DEPTH];
    logic [DEPTH-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data   = data_q[rd_idx];
    assign rd_valid  = vld_q[rd_idx];
    assign any_valid = |vld_q;
endmodule

// File: rtl/pgw_wtimer.sv
module pgw_wtimer #(
    parameter int CYCLES = 40,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int WC_CYCLES  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              cmd_rd,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              host_ack,
    input  logic              ack_val,
    input  logic              stop,
    input  logic              prot_fuse,
    input  logic [7:0]        mem_rdata,
    output logic              ack_out,
    output logic              busy,
    output logic [7:0]        rd_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    import pgw_pkg::*;

    localparam int COL_W    = $clog2(PAGE_BYTES);
    localparam int PG_W     = ADDR_W - COL_W;
    localparam int MEM_TOP  = (1 << ADDR_W) - 1;
    localparam int PROT_TOP = (ADDR_W >= 8) ? ((1 << (ADDR_W - 1)) - 1) : MEM_TOP;
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(PAGE_BYTES - 1);

    pgw_state_e        state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic [PG_W-1:0]   page_q;
    logic [COL_W-1:0]  col_q;
    logic [COL_W-1:0]  cidx_q;

    logic              buf_clr, buf_wr, buf_vld, buf_any;
    logic [7:0]        buf_rdata;
    logic              tmr_start, tmr_done;
    logic [ADDR_W-1:0] wr_addr;
    logic              in_write;

    pgw_pagebuf #(.DEPTH(PAGE_BYTES)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .wr_en     (buf_wr),
        .wr_idx    (col_q),
        .wr_data   (rx_byte),
        .rd_idx    (cidx_q),
        .rd_data   (buf_rdata),
        .rd_valid  (buf_vld),
        .any_valid (buf_any)
    );

    pgw_wtimer #(.CYCLES(WC_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_wr)      state_d = ST_WADDR;
                else if (cmd_rd) state_d = ST_RDATA;
            end
            ST_WADDR: begin
                if (cmd_rd)        state_d = ST_RDATA;
                else if (stop)     state_d = ST_IDLE;
                else if (rx_valid) state_d = ST_WDATA;
            end
            ST_WDATA: begin
                if (cmd_rd)    state_d = ST_RDATA;
                else if (stop) state_d = buf_any ? ST_COMMIT : ST_IDLE;
            end
            ST_RDATA: begin
                if (stop)                     state_d = ST_IDLE;
                else if (host_ack && !ack_val) state_d = ST_RDONE;
            end
            ST_RDONE: begin
                if (stop)        state_d = ST_IDLE;
                else if (cmd_wr) state_d = ST_WADDR;
                else if (cmd_rd) state_d = ST_RDATA;
            end
            ST_COMMIT: begin
                if (cidx_q == COL_LAST) state_d = ST_BUSY;
            end
            ST_BUSY: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            page_q  <= '0;
            col_q   <= '0;
            cidx_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WADDR && state_d == ST_WDATA) begin
                ptr_q  <= rx_byte[ADDR_W-1:0];
                page_q <= rx_byte[ADDR_W-1:COL_W];
                col_q  <= rx_byte[COL_W-1:0];
            end else if (buf_wr) begin
                col_q <= col_q + 1'b1;
                ptr_q <= {page_q, col_q + 1'b1};
            end else if (state_q == ST_RDATA && host_ack && !stop) begin
                ptr_q <= ptr_q + 1'b1;
            end
            cidx_q <= (state_q == ST_COMMIT) ? cidx_q + 1'b1 : '0;
        end
    end

    // outputs and strobes
    always_comb begin
        in_write  = (state_q == ST_WADDR) || (state_q == ST_WDATA);
        busy      = (state_q == ST_COMMIT) || (state_q == ST_BUSY);
        ack_out   = !busy && (cmd_wr || cmd_rd || (rx_valid && in_write));
        buf_clr   = cmd_wr && ((state_q == ST_IDLE) || (state_q == ST_RDONE));
        buf_wr    = (state_q == ST_WDATA) && rx_valid && !cmd_rd && !stop;
        tmr_start = (state_q == ST_COMMIT) && (cidx_q == COL_LAST);
        wr_addr   = {page_q, cidx_q};
        mem_addr  = (state_q == ST_COMMIT) ? wr_addr : ptr_q;
        mem_we    = (state_q == ST_COMMIT) && buf_vld &&
                    !(prot_fuse && (int'(wr_addr) <= PROT_TOP));
        mem_wdata = buf_rdata;
        rd_data   = (state_q == ST_RDATA) ? mem_rdata : 8'h00;
    end
endmodule

// File: rtl/pgw_ctrl_chk.sv
module pgw_ctrl_chk #(
    parameter int ADDR_W   = 8,
    parameter int COL_W    = 4,
    parameter int PROT_TOP = 127
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop,
    input logic              prot_fuse,
    input logic              busy,
    input logic              ack_out,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        rd_data
);
    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ack_out); // R6
    AST_BUSY_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rd_data == 8'h00)); // R6
    AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R5
    AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop)); // R5
    AST_PROT_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && prot_fuse) |-> (int'(mem_addr) > PROT_TOP)); // R10
    AST_WE_ONE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
        (mem_addr[ADDR_W-1:COL_W] == $past(mem_addr[ADDR_W-1:COL_W]))); // R3
endmodule

bind pgw_ctrl pgw_ctrl_chk #(.ADDR_W(ADDR_W), .COL_W(COL_W), .PROT_TOP(PROT_TOP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop      (stop),
    .prot_fuse (prot_fuse),
    .busy      (busy),
    .ack_out   (ack_out),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .rd_data   (rd_data)
);

// File: tb/tb_pgw_ctrl.sv
module tb_pgw_ctrl;
    localparam int WC = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 0, cmd_rd = 0, rx_valid = 0, host_ack = 0, ack_val = 0, stop = 0;
    logic       prot_fuse = 0;
    logic [7:0] rx_byte = '0;
    logic [7:0] mem_rdata, rd_data, mem_wdata, mem_addr;
    logic       ack_out, busy, mem_we;

    logic [7:0] bmem  [256];
    logic [7:0] ref_m [256];
    logic [7:0] ref_ptr;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    pgw_ctrl #(.ADDR_W(8), .PAGE_BYTES(16), .WC_CYCLES(WC)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .host_ack(host_ack),
        .ack_val(ack_val), .stop(stop), .prot_fuse(prot_fuse),
        .mem_rdata(mem_rdata), .ack_out(ack_out), .busy(busy),
        .rd_data(rd_data), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'(i * 7) ^ 8'h5A;
    endfunction

    function automatic bit is_prot(input logic [7:0] a);
        return prot_fuse && (a <= 8'h7F);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bmem[i] <= init_val(i);
        end else if (mem_we) begin
            bmem[mem_addr] <= mem_wdata;
        end
    end
    assign mem_rdata = bmem[mem_addr];

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // write: address byte then n data bytes then STOP; inj=1 pokes commands while busy
    task automatic do_write(input logic [7:0] a, input int n, input bit inj);
        logic [7:0] bufm [16];
        bit   vm [16];
        logic [3:0] col;
        int cycles, we_cnt, exp_we;
        col = a[3:0];
        for (int i = 0; i < 16; i++) vm[i] = 0;
        @(negedge clk); cmd_wr = 1; #1 chk("R11 cmd ack", ack_out, 1);
        @(negedge clk); cmd_wr = 0; rx_valid = 1; rx_byte = a; #1 chk("R11 addr ack", ack_out, 1);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rx_byte = 8'($urandom);
            bufm[col] = rx_byte; vm[col] = 1; col = col + 1'b1;
            #1;
            if (k == 0) chk("R10 R11 data ack", ack_out, 1);
            chk("R5 no early write", mem_we, 0);
        end
        @(negedge clk); rx_valid = 0; stop = 1;
        @(negedge clk); stop = 0;
        cycles = 0; we_cnt = 0;
        #1;
        while (busy === 1'b1 && cycles < 1000) begin
            we_cnt += int'(mem_we);
            cycles++;
            if (inj && cycles == 3) begin
                cmd_wr = 1; cmd_rd = 1; rx_valid = 1; rx_byte = 8'hC3; host_ack = 1;
                #1 chk("R6 silent while busy", ack_out, 0);
                chk("R6 rd_data quiet", rd_data, 0);
            end
            @(negedge clk);
            cmd_wr = 0; cmd_rd = 0; rx_valid = 0; host_ack = 0;
            #1;
        end
        exp_we = 0;
        for (int i = 0; i < 16; i++) begin
            if (vm[i] && !is_prot({a[7:4], 4'(i)})) begin
                exp_we++;
                ref_m[{a[7:4], 4'(i)}] = bufm[i];
            end
        end
        chk((n == 0) ? "R9 no busy" : "R5 busy length", cycles, (n == 0) ? 0 : 16 + WC);
        chk("R4 written locations", we_cnt, exp_we);
        ref_ptr = (n == 0) ? a : {a[7:4], col};
    endtask

    // read n bytes; set_a=1 does an address-only write then a repeated start
    task automatic do_read(input bit set_a, input logic [7:0] a, input int n, input string req);
        if (set_a) begin
            @(negedge clk); cmd_wr = 1;
            @(negedge clk); cmd_wr = 0; rx_valid = 1; rx_byte = a;
            @(negedge clk); rx_valid = 0; cmd_rd = 1;
            ref_ptr = a;
        end else begin
            @(negedge clk); cmd_rd = 1;
        end
        @(negedge clk); cmd_rd = 0;
        for (int k = 0; k < n; k++) begin
            #1 chk(req, rd_data, ref_m[ref_ptr]);
            host_ack = 1; ack_val = (k != n - 1);
            ref_ptr = ref_ptr + 1'b1;
            @(negedge clk); host_ack = 0; ack_val = 0;
        end
        stop = 1;
        @(negedge clk); stop = 0;
        #1 chk("R9 read leaves idle", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) ref_m[i] = init_val(i);
        ref_ptr = 8'h00;
        repeat (4) @(negedge clk);
        #1 chk("R1 busy reset", busy, 0);
        chk("R1 ack reset", ack_out, 0);
        chk("R1 we reset", mem_we, 0);
        @(negedge clk); rst_n = 1;
        do_read(0, 8'h00, 1, "R1 pointer starts at 0");

        do_write(8'h23, 3, 0);
        do_read(0, 8'h00, 2, "R7 current read after write");
        do_read(1, 8'h20, 8, "R2 byte and page write");

        do_write(8'h3C, 20, 0);
        do_read(0, 8'h00, 1, "R7 pointer wrapped in page");
        do_read(1, 8'h30, 16, "R3 page wrap overwrite");

        do_write(8'h55, 2, 0);
        do_read(1, 8'h50, 16, "R4 partial page");

        do_write(8'h77, 0, 0);
        do_read(0, 8'h00, 2, "R9 address only write");

        do_read(1, 8'hFE, 4, "R8 sequential wrap");
        do_read(0, 8'h00, 1, "R7 current after read");

        do_write(8'h90, 5, 1);
        do_read(1, 8'h90, 8, "R6 ignored while busy");

        for (int t = 0; t < 30; t++) begin
            do_write(8'($urandom), int'($urandom_range(0, 20)), t[2]);
            do_read(t[0], 8'($urandom), int'($urandom_range(1, 6)), "R2 random");
        end

        prot_fuse = 1;
        do_write(8'h10, 4, 0);
        do_read(1, 8'h10, 4, "R10 lower half protected");
        do_write(8'h7C, 8, 0);
        do_read(1, 8'h70, 16, "R10 top protected page");
        do_write(8'h84, 4, 0);
        do_read(1, 8'h84, 4, "R10 upper half open");
        for (int t = 0; t < 10; t++) begin
            do_write(8'($urandom), int'($urandom_range(1, 18)), 0);
            do_read(1, 8'($urandom), int'($urandom_range(1, 6)), "R10 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule